// File: doc/BRIEF.md
# Parallel Binary BCH Syndrome Generator

This block forms the 2t syndromes of a received binary BCH word over GF(2^m). It sits at the front of a page-read decoder for NAND storage. Received bits stream in P at a time, qualified by a valid strobe. A start marker opens a word and an end marker closes it. Once the last beat has been taken, the block presents all 2t syndromes together, with a one-cycle valid pulse and a flag that is high when no error was detected. Locating the errors is the job of later stages.

Only the t odd-indexed syndromes have accumulators, and each one is updated in Horner form on every beat. For a binary code, each even-indexed syndrome equals the square of a lower one. Those are therefore produced by fixed XOR squaring networks on the outputs. Shortened codes need no special handling: the sender pads the front of the word with zero bits until its length is a multiple of P, and those bits do not change the result.

The field width M, the primitive polynomial POLY, the correction capability T and the beat width P are parameters.

Top module: `bch_syndrome_gen`

## Requirements
- R1: For a received word r_0..r_{n-1}, output syndrome S_i equals the XOR over j of r_j·α^(i·j) for every i from 1 to 2T. α is a root of POLY (default x^4+x+1). Bits arrive highest degree first, and within a beat in_bits[P-1] carries the highest degree. S_i occupies synd[(i-1)*M +: M].
- R2: For every i from 1 to T, S_2i equals S_i squared in GF(2^M).
- R3: A beat with in_sof high discards everything accumulated so far and loads that beat's bits as the first bits of a new word. This holds even when the previous word never ended.
- R4: Cycles with in_valid low leave the accumulation unchanged, whatever in_sof, in_eof and in_bits carry.
- R5: A shortened word whose length is not a multiple of P is handled by prefixing zero bits. Codewords of the shortened code, including a word of a single beat carrying both markers, give the syndromes of R1.
- R6: synd_valid is high for exactly the one cycle after each beat that has both in_valid and in_eof high, and low otherwise.
- R7: synd and synd_zero hold their values from one synd_valid pulse until the next.
- R8: synd_zero is high exactly when all 2T syndromes are zero.
- R9: After reset, synd is all zero, synd_zero is high and synd_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Beat qualifier |
| in_sof | input | 1 | First beat of a word |
| in_eof | input | 1 | Last beat of a word |
| in_bits | input | P | Received bits; bit P-1 has the highest degree |
| synd_valid | output | 1 | One-cycle pulse when new syndromes are presented |
| synd | output | 2*T*M | S_1..S_2T, S_i at bits (i-1)*M and up |
| synd_zero | output | 1 | All syndromes zero |

## Verification
The bench builds the block with GF(2^4), T=2 and P=2, which gives the BCH(15,7) double-error code. At this size every syndrome can be computed directly as a sum of α powers. The bench can also construct real codewords, single and double errors, and the all-ones word. Because 15 is odd, every word is fed with one leading zero bit, so shortening is exercised on every run. The two-bit beat is wide enough to show the per-beat weights and the α^(iP) step, and it still allows a single-beat word that carries both markers.

// File: rtl/bch_syndrome_gen.sv
module bch_syndrome_gen #(
  parameter int M    = 4,
  parameter int T    = 2,
  parameter int P    = 2,
  parameter int POLY = 'h13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_sof,
  input  logic             in_eof,
  input  logic [P-1:0]     in_bits,
  output logic             synd_valid,
  output logic [2*T*M-1:0] synd,
  output logic             synd_zero
);
  localparam int NZ = (1 << M) - 1;
  localparam logic [M-1:0] RED = POLY[M-1:0];

  function automatic logic [M-1:0] mulx(input logic [M-1:0] a);
    return {a[M-2:0], 1'b0} ^ (a[M-1] ? RED : '0);
  endfunction

  function automatic logic [M-1:0] gf_mul(input logic [M-1:0] a, input logic [M-1:0] b);
    logic [M-1:0] r, x;
    r = '0;
    x = a;
    for (int k = 0; k < M; k++) begin
      if (b[k]) r = r ^ x;
      x = mulx(x);
    end
    return r;
  endfunction

  function automatic logic [M-1:0] alpha_pow(input int e);
    logic [M-1:0] r;
    r = 1;
    for (int k = 0; k < e % NZ; k++) r = mulx(r);
    return r;
  endfunction

  function automatic logic [M-1:0] sq_n(input logic [M-1:0] a, input int n);
    logic [M-1:0] r;
    r = a;
    for (int k = 0; k < n; k++) r = gf_mul(r, r);
    return r;
  endfunction

  function automatic int odd_of(input int i);
    int v;
    v = i;
    while (v % 2 == 0) v = v / 2;
    return v;
  endfunction

  function automatic int twos_of(input int i);
    int v, n;
    v = i;
    n = 0;
    while (v % 2 == 0) begin
      v = v / 2;
      n++;
    end
    return n;
  endfunction

  logic [T*M-1:0] odd_flat;
  logic           vld_q;

  for (genvar j = 0; j < T; j++) begin : g_odd
    localparam int IDX = 2*j + 1;
    localparam logic [M-1:0] STEP = alpha_pow(IDX*P);
    logic [M-1:0] term [P];
    logic [M-1:0] acc, nx, oq;

    for (genvar k = 0; k < P; k++) begin : g_w
      localparam logic [M-1:0] W = alpha_pow(IDX*k);
      assign term[k] = in_bits[k] ? W : '0;
    end

    always_comb begin
      nx = in_sof ? '0 : gf_mul(acc, STEP);
      for (int k = 0; k < P; k++) nx = nx ^ term[k];
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        acc <= '0;
        oq  <= '0;
      end else if (in_valid) begin
        acc <= nx;
        if (in_eof) oq <= nx;
      end
    end

    assign odd_flat[j*M +: M] = oq;
  end

  for (genvar i = 1; i <= 2*T; i++) begin : g_out
    localparam int BASE = odd_of(i);
    localparam int NSQ  = twos_of(i);
    assign synd[(i-1)*M +: M] = sq_n(odd_flat[((BASE-1)/2)*M +: M], NSQ);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= in_valid & in_eof;
  end

  assign synd_valid = vld_q;
  assign synd_zero  = ~|odd_flat;
endmodule

// File: rtl/bch_syndrome_gen_chk.sv
module bch_syndrome_gen_chk #(
  parameter int M    = 4,
  parameter int T    = 2,
  parameter int POLY = 'h13
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_eof,
  input logic             synd_valid,
  input logic [2*T*M-1:0] synd,
  input logic             synd_zero
);
  localparam logic [M-1:0] RED = POLY[M-1:0];

  function automatic logic [M-1:0] sq(input logic [M-1:0] a);
    logic [M-1:0] r, x;
    r = '0;
    x = a;
    for (int k = 0; k < M; k++) begin
      if (a[k]) r = r ^ x;
      x = {x[M-2:0], 1'b0} ^ (x[M-1] ? RED : '0);
    end
    return r;
  endfunction

  p_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_eof) |=> synd_valid);
  p_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_eof) |=> !synd_valid);
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !synd_valid |-> ($stable(synd) && $stable(synd_zero)));
  p_zero_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    synd_zero == (synd == '0));

  for (genvar j = 1; j <= T; j++) begin : g_sq
    p_even_square_r2: assert property (@(posedge clk) disable iff (!rst_n)
      synd[(2*j-1)*M +: M] == sq(synd[(j-1)*M +: M]));
  end
endmodule

bind bch_syndrome_gen bch_syndrome_gen_chk #(.M(M), .T(T), .POLY(POLY)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_eof(in_eof),
  .synd_valid(synd_valid), .synd(synd), .synd_zero(synd_zero)
);

// File: tb/bch_syndrome_gen_tb_top.sv
`timescale 1ns/1ps
module bch_syndrome_gen_tb_top;
  localparam int M = 4, T = 2, P = 2, POLY = 'h13;
  localparam int NB = 16;
  localparam int NV = 7;
  localparam logic [15:0] VEC [NV] = '{
    16'h0000, 16'h01D1, 16'h0273, 16'h01C1, 16'h4272, 16'h7FFF, 16'h5A3C
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
  logic [P-1:0] in_bits = '0;
  logic synd_valid, synd_zero;
  logic [2*T*M-1:0] synd;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  bch_syndrome_gen #(.M(M), .T(T), .P(P), .POLY(POLY)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof),
    .in_bits(in_bits), .synd_valid(synd_valid), .synd(synd), .synd_zero(synd_zero)
  );

  function automatic logic [3:0] apow(input int e);
    logic [3:0] r;
    r = 4'd1;
    for (int k = 0; k < e % 15; k++) r = r[3] ? ({r[2:0], 1'b0} ^ 4'h3) : {r[2:0], 1'b0};
    return r;
  endfunction

  function automatic logic [15:0] exp_synd(input logic [15:0] w);
    logic [15:0] r;
    r = '0;
    for (int i = 1; i <= 4; i++)
      for (int j = 0; j < 16; j++)
        if (w[j]) r[(i-1)*4 +: 4] = r[(i-1)*4 +: 4] ^ apow(i*j);
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic beat(input bit s, input bit e, input logic [P-1:0] b);
    in_valid = 1'b1; in_sof = s; in_eof = e; in_bits = b;
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0; in_bits = '0;
  endtask

  task automatic send(input logic [15:0] w, input bit gaps);
    for (int b = 0; b < NB/P; b++) begin
      beat(b == 0, b == NB/P - 1, w[15-2*b -: 2]);
      if (gaps && b < NB/P - 1) begin
        in_sof = 1'b1; in_eof = 1'b1; in_bits = 2'b11;
        @(negedge clk);
        in_sof = 1'b0; in_eof = 1'b0; in_bits = '0;
      end
    end
  endtask

  task automatic expect_word(input logic [15:0] w, input string req);
    logic [15:0] e;
    e = exp_synd(w);
    check(synd_valid == 1'b1, {req, " R6 pulse"}, synd_valid, 1);
    check(synd == e, {req, " R1 syndromes"}, synd, e);
    check(synd_zero == (e == '0), {req, " R8 zero flag"}, synd_zero, e == '0);
    @(negedge clk);
    check(synd_valid == 1'b0, "R6 pulse one cycle", synd_valid, 0);
    check(synd == e, "R7 hold", synd, e);
  endtask

  initial begin
    #1_000_000;
    fails++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(synd == '0, "R9 reset synd", synd, 0);
    check(synd_zero == 1'b1, "R9 reset zero", synd_zero, 1);
    check(synd_valid == 1'b0, "R9 reset valid", synd_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R2 R5 R8: table walk; codewords of BCH(15,7) padded with one leading zero
    for (int v = 0; v < NV; v++) begin
      send(VEC[v], 1'b0);
      expect_word(VEC[v], "R1 table");
    end
    check(exp_synd(16'h01D1) == '0, "R5 shortened codeword sanity", exp_synd(16'h01D1), 0);

    // R4: idle beats with noisy markers and bits in between
    send(16'h5A3C, 1'b1);
    expect_word(16'h5A3C, "R4 gaps");

    // R3: aborted word then restart
    beat(1'b1, 1'b0, 2'b11);
    beat(1'b0, 1'b0, 2'b10);
    beat(1'b0, 1'b0, 2'b01);
    check(synd == exp_synd(16'h5A3C), "R7 hold across partial word", synd, exp_synd(16'h5A3C));
    send(16'h01C1, 1'b0);
    expect_word(16'h01C1, "R3 restart");

    // R5: single-beat word with both markers, bits r1=1 r0=0
    beat(1'b1, 1'b1, 2'b10);
    expect_word(16'h0002, "R5 single beat");

    // R6: back-to-back single-beat words
    beat(1'b1, 1'b1, 2'b01);
    check(synd_valid == 1'b1 && synd == exp_synd(16'h0001), "R6 back-to-back first", synd, exp_synd(16'h0001));
    beat(1'b1, 1'b1, 2'b11);
    expect_word(16'h0003, "R6 back-to-back second");

    repeat (3) @(negedge clk);
    check(synd == exp_synd(16'h0003), "R7 long hold", synd, exp_synd(16'h0003));

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule